// File: doc/BRIEF.md
# Processor Port Trailer Tag Handler

This block sits between a three-port switch and the processor attached to its third port. It handles two independent byte-wide streams, each framed by valid, start-of-frame and end-of-frame strobes. Frames going to the processor get a one-byte trailer that names the port the frame arrived on. The block puts this trailer between the payload and a freshly computed frame check sequence (FCS). Frames coming from the processor carry a trailer chosen by software. The block reads it, reports a destination port mask and a priority, removes the trailer and writes a new FCS.

Every frame arrives with a 4-byte FCS, which the block discards and replaces. A single enable input decides, at the start of each frame, whether that frame is tagged or stripped, or passed through untouched. Frames in one direction must be separated by at least five idle cycles. A frame must carry at least one payload byte.

Top module: `ttag_port_bridge`

## Requirements
- R1: After reset, both output streams are idle: no valid, start or end strobe, and the destination mask and priority are zero.
- R2: A frame whose first byte arrives while `tag_en` is low is copied byte for byte, strobes included. Each byte appears on the output one cycle after it is taken. The mask and priority stay zero.
- R3: Toward the processor, the last four input bytes are dropped. The remaining payload is sent in order, followed by one trailer byte and then four FCS bytes, so the frame grows by one byte. Bits [1:0] of the trailer equal `tx_in_port` as sampled at start of frame, and bits [7:2] are zero.
- R4: The new FCS is computed as follows:
  - It is a CRC-32 with polynomial 0x04C11DB7 in reflected (least-significant-bit-first) form, an all-ones start value and a complemented result.
  - It is sent least significant byte first.
  - Toward the processor it covers the payload plus the trailer. Toward the switch it covers the payload alone.
  - For example, the payload "123456789" gives the bytes 26 39 F4 CB.
- R5: From the processor, the byte just before the final four is taken as the trailer. The trailer and the old FCS are removed, and the payload is followed by a new FCS, so the frame shrinks by one byte.
- R6: The trailer field [1:0] selects the destination:
  - A value p from 1 to 3 sets bit p-1 of `rx_out_mask`.
  - A value of 0 gives a zero mask, which means normal lookup.
  - The mask is driven only with the end-of-frame byte and is zero on every other cycle.
- R7: `rx_out_prio` equals trailer bits [3:2] on the end-of-frame byte and is zero on every other cycle.
- R8: Trailer bits [7:4] have no effect on any output.
- R9: `tag_en` is sampled only on a start-of-frame byte, separately for each direction. A change in the middle of a frame does not alter how that frame is handled.
- R10: For a frame sent with no gaps while enabled, the output start-of-frame appears a fixed number of cycles after the input start-of-frame: 4 cycles toward the processor and 5 toward the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tag_en | input | 1 | Trailer mode enable, sampled at each start of frame |
| tx_in_valid | input | 1 | Byte valid, switch to processor |
| tx_in_sof | input | 1 | First byte of frame |
| tx_in_eof | input | 1 | Last byte of frame |
| tx_in_data | input | 8 | Frame byte |
| tx_in_port | input | 2 | Ingress port number, sampled with start of frame |
| tx_out_valid | output | 1 | Byte valid toward processor |
| tx_out_sof | output | 1 | First byte of output frame |
| tx_out_eof | output | 1 | Last byte of output frame |
| tx_out_data | output | 8 | Output byte |
| rx_in_valid | input | 1 | Byte valid, processor to switch |
| rx_in_sof | input | 1 | First byte of frame |
| rx_in_eof | input | 1 | Last byte of frame |
| rx_in_data | input | 8 | Frame byte |
| rx_out_valid | output | 1 | Byte valid toward switch |
| rx_out_sof | output | 1 | First byte of output frame |
| rx_out_eof | output | 1 | Last byte of output frame |
| rx_out_data | output | 8 | Output byte |
| rx_out_mask | output | 3 | One-hot destination, zero for lookup, valid with end of frame |
| rx_out_prio | output | 2 | Priority, valid with end of frame |

## Verification
The bench checks the FCS against a known answer. A design that computed the CRC in the wrong bit order, left out the final complement or sent the bytes in the wrong order would fail that check, even if its CRC matched another copy of the same mistake.

Some trailers set the upper nibble. A design that decoded bits [7:4] into the mask or priority would then report a different destination.

Other frames flip `tag_en` in the middle. A design that followed the live enable instead of the value latched at start of frame would split the frame, leaving part of it bypassed and part of it tagged.

Mask values of 0 and 3 are both exercised, along with output lengths and start-of-frame latency. These catch an off-by-one in the delay line, which would leak the trailer into the payload or cut off the last payload byte.

// File: rtl/ttag_port_bridge.sv
module ttag_port_bridge #(
  parameter logic [31:0] CRC_POLY_REFL = 32'hEDB88320
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tag_en,
  input  logic       tx_in_valid,
  input  logic       tx_in_sof,
  input  logic       tx_in_eof,
  input  logic [7:0] tx_in_data,
  input  logic [1:0] tx_in_port,
  output logic       tx_out_valid,
  output logic       tx_out_sof,
  output logic       tx_out_eof,
  output logic [7:0] tx_out_data,
  input  logic       rx_in_valid,
  input  logic       rx_in_sof,
  input  logic       rx_in_eof,
  input  logic [7:0] rx_in_data,
  output logic       rx_out_valid,
  output logic       rx_out_sof,
  output logic       rx_out_eof,
  output logic [7:0] rx_out_data,
  output logic [2:0] rx_out_mask,
  output logic [1:0] rx_out_prio
);

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] x;
    x = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++)
      x = x[0] ? ((x >> 1) ^ CRC_POLY_REFL) : (x >> 1);
    return x;
  endfunction

  typedef enum logic [1:0] {S_RUN, S_TAG, S_FCS} st_t;

  // ---------------- switch to processor: insert trailer ----------------
  st_t        ist;
  logic [7:0] ib [4];
  logic [2:0] icnt;
  logic       ion, ifirst;
  logic [1:0] iport, iidx;
  logic [31:0] icrc;
  logic [31:0] icrc_sh;
  logic [7:0]  itag;

  assign icrc_sh = icrc >> {iidx, 3'b000};
  assign itag    = {6'b0, iport};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist <= S_RUN; icnt <= '0; ion <= 1'b0; ifirst <= 1'b0;
      iport <= '0; iidx <= '0; icrc <= '1;
      for (int i = 0; i < 4; i++) ib[i] <= '0;
      tx_out_valid <= 1'b0; tx_out_sof <= 1'b0; tx_out_eof <= 1'b0; tx_out_data <= '0;
    end else begin
      tx_out_valid <= 1'b0; tx_out_sof <= 1'b0; tx_out_eof <= 1'b0;
      case (ist)
        S_RUN: if (tx_in_valid) begin
          if (tx_in_sof ? !tag_en : !ion) begin
            tx_out_valid <= 1'b1; tx_out_sof <= tx_in_sof;
            tx_out_eof <= tx_in_eof; tx_out_data <= tx_in_data;
            if (tx_in_sof) ion <= 1'b0;
          end else if (tx_in_sof) begin
            ion <= 1'b1; iport <= tx_in_port; icrc <= '1;
            ifirst <= 1'b1; icnt <= 3'd1; ib[0] <= tx_in_data;
          end else begin
            if (icnt == 3'd4) begin
              tx_out_valid <= 1'b1; tx_out_sof <= ifirst; tx_out_data <= ib[0];
              ifirst <= 1'b0; icrc <= crc_byte(icrc, ib[0]);
              ib[0] <= ib[1]; ib[1] <= ib[2]; ib[2] <= ib[3]; ib[3] <= tx_in_data;
            end else begin
              ib[icnt[1:0]] <= tx_in_data;
              icnt <= icnt + 3'd1;
            end
            if (tx_in_eof) ist <= S_TAG;
          end
        end
        S_TAG: begin
          tx_out_valid <= 1'b1; tx_out_data <= itag;
          icrc <= crc_byte(icrc, itag);
          iidx <= '0; ist <= S_FCS;
        end
        default: begin
          tx_out_valid <= 1'b1; tx_out_data <= ~icrc_sh[7:0];
          tx_out_eof <= (iidx == 2'd3);
          iidx <= iidx + 2'd1;
          if (iidx == 2'd3) ist <= S_RUN;
        end
      endcase
    end
  end

  // ---------------- processor to switch: strip trailer ----------------
  st_t        rst_q;
  logic [7:0] rb [5];
  logic [2:0] rcnt;
  logic       ron, rfirst;
  logic [1:0] ridx;
  logic [7:0] rtag;
  logic [31:0] rcrc;
  logic [31:0] rcrc_sh;
  logic [2:0]  rmask_dec;

  assign rcrc_sh   = rcrc >> {ridx, 3'b000};
  assign rmask_dec = (rtag[1:0] == 2'd0) ? 3'b000 : (3'b001 << (rtag[1:0] - 2'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= S_RUN; rcnt <= '0; ron <= 1'b0; rfirst <= 1'b0;
      ridx <= '0; rtag <= '0; rcrc <= '1;
      for (int i = 0; i < 5; i++) rb[i] <= '0;
      rx_out_valid <= 1'b0; rx_out_sof <= 1'b0; rx_out_eof <= 1'b0; rx_out_data <= '0;
      rx_out_mask <= '0; rx_out_prio <= '0;
    end else begin
      rx_out_valid <= 1'b0; rx_out_sof <= 1'b0; rx_out_eof <= 1'b0;
      rx_out_mask <= '0; rx_out_prio <= '0;
      case (rst_q)
        S_RUN: if (rx_in_valid) begin
          if (rx_in_sof ? !tag_en : !ron) begin
            rx_out_valid <= 1'b1; rx_out_sof <= rx_in_sof;
            rx_out_eof <= rx_in_eof; rx_out_data <= rx_in_data;
            if (rx_in_sof) ron <= 1'b0;
          end else if (rx_in_sof) begin
            ron <= 1'b1; rcrc <= '1; rfirst <= 1'b1;
            rcnt <= 3'd1; rb[0] <= rx_in_data;
          end else begin
            if (rcnt == 3'd5) begin
              rx_out_valid <= 1'b1; rx_out_sof <= rfirst; rx_out_data <= rb[0];
              rfirst <= 1'b0; rcrc <= crc_byte(rcrc, rb[0]);
              rb[0] <= rb[1]; rb[1] <= rb[2]; rb[2] <= rb[3]; rb[3] <= rb[4]; rb[4] <= rx_in_data;
            end else begin
              rb[rcnt] <= rx_in_data;
              rcnt <= rcnt + 3'd1;
            end
            if (rx_in_eof) begin
              rtag <= rb[1];
              ridx <= '0;
              rst_q <= S_FCS;
            end
          end
        end
        default: begin
          rx_out_valid <= 1'b1; rx_out_data <= ~rcrc_sh[7:0];
          ridx <= ridx + 2'd1;
          if (ridx == 2'd3) begin
            rx_out_eof <= 1'b1;
            rx_out_mask <= rmask_dec;
            rx_out_prio <= rtag[3:2];
            rst_q <= S_RUN;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ttag_port_bridge_chk.sv
module ttag_port_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tag_en,
  input logic       tx_in_valid,
  input logic       tx_in_sof,
  input logic [7:0] tx_in_data,
  input logic       tx_out_valid,
  input logic       tx_out_sof,
  input logic       tx_out_eof,
  input logic [7:0] tx_out_data,
  input logic       rx_in_valid,
  input logic       rx_in_sof,
  input logic [7:0] rx_in_data,
  input logic       rx_out_valid,
  input logic       rx_out_sof,
  input logic       rx_out_eof,
  input logic [7:0] rx_out_data,
  input logic [2:0] rx_out_mask,
  input logic [1:0] rx_out_prio
);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tx_out_valid && !rx_out_valid && rx_out_mask == 3'b0));

  a_r2_tx_bypass_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_sof && !tag_en) |=>
      (tx_out_valid && tx_out_sof && tx_out_data == $past(tx_in_data)));

  a_r2_rx_bypass_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_sof && !tag_en) |=>
      (rx_out_valid && rx_out_sof && rx_out_data == $past(rx_in_data) && rx_out_mask == 3'b0));

  a_r10_tx_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_sof && tag_en) |=> !tx_out_valid);

  a_r10_rx_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_sof && tag_en) |=> !rx_out_valid);

  a_r3_strobes_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_sof || tx_out_eof) |-> tx_out_valid);

  a_r6_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_out_mask));

  a_r6_mask_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_mask != 3'b0) |-> (rx_out_valid && rx_out_eof));

  a_r7_prio_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_prio != 2'b0) |-> (rx_out_valid && rx_out_eof));

endmodule

bind ttag_port_bridge ttag_port_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tag_en(tag_en),
  .tx_in_valid(tx_in_valid), .tx_in_sof(tx_in_sof), .tx_in_data(tx_in_data),
  .tx_out_valid(tx_out_valid), .tx_out_sof(tx_out_sof), .tx_out_eof(tx_out_eof),
  .tx_out_data(tx_out_data),
  .rx_in_valid(rx_in_valid), .rx_in_sof(rx_in_sof), .rx_in_data(rx_in_data),
  .rx_out_valid(rx_out_valid), .rx_out_sof(rx_out_sof), .rx_out_eof(rx_out_eof),
  .rx_out_data(rx_out_data), .rx_out_mask(rx_out_mask), .rx_out_prio(rx_out_prio)
);

// File: tb/sim_ttag_port_bridge.sv
`timescale 1ns/1ps
module sim_ttag_port_bridge;
  logic clk = 1'b0, rst_n = 1'b0, tag_en = 1'b0;
  logic tx_in_valid = 0, tx_in_sof = 0, tx_in_eof = 0;
  logic [7:0] tx_in_data = 0;
  logic [1:0] tx_in_port = 0;
  logic rx_in_valid = 0, rx_in_sof = 0, rx_in_eof = 0;
  logic [7:0] rx_in_data = 0;
  logic tx_out_valid, tx_out_sof, tx_out_eof, rx_out_valid, rx_out_sof, rx_out_eof;
  logic [7:0] tx_out_data, rx_out_data;
  logic [2:0] rx_out_mask;
  logic [1:0] rx_out_prio;

  ttag_port_bridge u0 (.*);

  always #10 clk = ~clk;

  int nchk = 0, nbad = 0, cyc = 0;
  logic [7:0] fin [80];
  logic [7:0] ex [80];
  logic [7:0] tcap [80];
  logic [7:0] rcap [80];
  int tn, rn, tsof_c, rsof_c, isof_c, rbad;
  logic [2:0] rmask;
  logic [1:0] rprio;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tx_out_valid) begin
      if (tn < 80) tcap[tn] = tx_out_data;
      if (tx_out_sof) tsof_c = cyc;
      tn++;
    end
    if (rx_out_valid) begin
      if (rn < 80) rcap[rn] = rx_out_data;
      if (rx_out_sof) rsof_c = cyc;
      if (rx_out_eof) begin rmask = rx_out_mask; rprio = rx_out_prio; end
      rn++;
    end
    if (!(rx_out_valid && rx_out_eof) && (rx_out_mask != 0 || rx_out_prio != 0)) rbad++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bcrc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ ex[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic clear_caps();
    tn = 0; rn = 0; tsof_c = -1; rsof_c = -1; rbad = 0; rmask = 0; rprio = 0;
  endtask

  task automatic drive_tx(input int n, input logic [1:0] port, input int flip);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == flip) tag_en = ~tag_en;
      tx_in_valid = 1; tx_in_sof = (i == 0); tx_in_eof = (i == n - 1);
      tx_in_data = fin[i]; tx_in_port = port;
      if (i == 0) isof_c = cyc + 1;
    end
    @(negedge clk);
    tx_in_valid = 0; tx_in_sof = 0; tx_in_eof = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic drive_rx(input int n, input int flip);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == flip) tag_en = ~tag_en;
      rx_in_valid = 1; rx_in_sof = (i == 0); rx_in_eof = (i == n - 1);
      rx_in_data = fin[i];
      if (i == 0) isof_c = cyc + 1;
    end
    @(negedge clk);
    rx_in_valid = 0; rx_in_sof = 0; rx_in_eof = 0;
    repeat (8) @(negedge clk);
  endtask

  // R3 R4 R10 R9: tagged frame toward the processor
  task automatic t_tx_tag(input int len, input logic [1:0] port, input int seed, input int flip, input string req);
    logic [31:0] c;
    for (int i = 0; i < len; i++) begin fin[i] = 8'(seed + i * 7); ex[i] = fin[i]; end
    for (int i = 0; i < 4; i++) fin[len + i] = 8'hA5 ^ 8'(i);
    ex[len] = {6'b0, port};
    c = bcrc(len + 1);
    for (int i = 0; i < 4; i++) ex[len + 1 + i] = c[8*i +: 8];
    clear_caps();
    drive_tx(len + 4, port, flip);
    chk(tn == len + 5, {req, " R3 length"}, tn, len + 5);
    for (int i = 0; i < len + 5; i++)
      chk(tcap[i] == ex[i], (i <= len) ? {req, " R3 byte"} : {req, " R4 fcs"}, tcap[i], ex[i]);
    chk(tsof_c - isof_c == 4, {req, " R10 latency"}, tsof_c - isof_c, 4);
  endtask

  // R5 R6 R7 R10: trailer stripped from processor frame
  task automatic t_rx_tag(input int len, input logic [7:0] tag, input int seed, input int flip, input string req);
    logic [31:0] c;
    logic [2:0] em;
    for (int i = 0; i < len; i++) begin fin[i] = 8'(seed + i * 13); ex[i] = fin[i]; end
    fin[len] = tag;
    for (int i = 0; i < 4; i++) fin[len + 1 + i] = 8'h3C + 8'(i);
    c = bcrc(len);
    for (int i = 0; i < 4; i++) ex[len + i] = c[8*i +: 8];
    em = (tag[1:0] == 0) ? 3'b000 : (3'b001 << (tag[1:0] - 1));
    clear_caps();
    drive_rx(len + 5, flip);
    chk(rn == len + 4, {req, " R5 length"}, rn, len + 4);
    for (int i = 0; i < len + 4; i++)
      chk(rcap[i] == ex[i], (i < len) ? {req, " R5 byte"} : {req, " R4 fcs"}, rcap[i], ex[i]);
    chk(rmask == em, {req, " R6 mask"}, rmask, em);
    chk(rprio == tag[3:2], {req, " R7 prio"}, rprio, tag[3:2]);
    chk(rbad == 0, {req, " R6 R7 outside eof"}, rbad, 0);
    chk(rsof_c - isof_c == 5, {req, " R10 latency"}, rsof_c - isof_c, 5);
  endtask

  // R2 R9: bypassed frames in both directions
  task automatic t_bypass(input int len, input int flip, input string req);
    for (int i = 0; i < len; i++) fin[i] = 8'(8'h51 + i * 3);
    clear_caps();
    drive_tx(len, 2'd2, flip);
    if (flip >= 0) tag_en = 1'b0;
    chk(tn == len, {req, " R2 tx length"}, tn, len);
    for (int i = 0; i < len; i++) chk(tcap[i] == fin[i], {req, " R2 tx byte"}, tcap[i], fin[i]);
    chk(tsof_c - isof_c == 0, {req, " R2 tx latency"}, tsof_c - isof_c, 0);
    clear_caps();
    drive_rx(len, flip);
    if (flip >= 0) tag_en = 1'b0;
    chk(rn == len, {req, " R2 rx length"}, rn, len);
    for (int i = 0; i < len; i++) chk(rcap[i] == fin[i], {req, " R2 rx byte"}, rcap[i], fin[i]);
    chk(rmask == 0 && rprio == 0 && rbad == 0, {req, " R2 rx mask prio"}, {rmask, rprio}, 0);
  endtask

  // R4: known-answer FCS
  task automatic t_known();
    string s = "123456789";
    for (int i = 0; i < 9; i++) fin[i] = s[i];
    fin[9] = 8'h00;
    for (int i = 0; i < 4; i++) fin[10 + i] = 8'h00;
    clear_caps();
    drive_rx(14, -1);
    chk(rn == 13, "R4 known length", rn, 13);
    chk(rcap[9] == 8'h26, "R4 known fcs0", rcap[9], 8'h26);
    chk(rcap[10] == 8'h39, "R4 known fcs1", rcap[10], 8'h39);
    chk(rcap[11] == 8'hF4, "R4 known fcs2", rcap[11], 8'hF4);
    chk(rcap[12] == 8'hCB, "R4 known fcs3", rcap[12], 8'hCB);
    chk(rmask == 0, "R6 lookup mask", rmask, 0);
  endtask

  initial begin
    #(20 * 100000);
    nbad++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_out_valid == 0 && rx_out_valid == 0, "R1 idle in reset", {tx_out_valid, rx_out_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_out_valid == 0 && rx_out_valid == 0 && rx_out_mask == 0 && rx_out_prio == 0,
        "R1 idle after reset", {tx_out_valid, rx_out_valid, rx_out_mask, rx_out_prio}, 0);

    tag_en = 1'b1;
    t_tx_tag(10, 2'd1, 16, -1, "port1");
    t_tx_tag(1, 2'd2, 200, -1, "port2 short");
    t_tx_tag(23, 2'd3, 99, -1, "port3");
    t_known();
    t_rx_tag(12, 8'h0E, 5, -1, "dest2 prio3");
    t_rx_tag(1, 8'h07, 77, -1, "dest3 prio1 short");
    t_rx_tag(8, 8'h01, 40, -1, "R8 base");
    t_rx_tag(8, 8'hF1, 40, -1, "R8 upper bits set");
    t_rx_tag(9, 8'hA4, 3, -1, "R8 lookup prio1");

    tag_en = 1'b1;
    t_tx_tag(9, 2'd1, 60, 3, "R9 tx disable midframe");
    tag_en = 1'b1;
    t_rx_tag(9, 8'h0B, 61, 3, "R9 rx disable midframe");

    tag_en = 1'b0;
    t_bypass(14, -1, "bypass");
    tag_en = 1'b0;
    t_bypass(10, 4, "R9 enable midframe");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule